// File: doc/BRIEF.md
# SMBus Byte-Register Slave

This block is the bus-facing half of a small register bank that a host reaches over a two-wire SMBus. It oversamples SCL and SDA with the system clock, recognises START and STOP, and matches the 7-bit slave address. One strap input chooses between two parameterised addresses. The block then carries out either a Write Byte (address+W, command, data) or a Read Byte (address+W, command, repeated START, address+R, data returned to the host). SDA is only ever pulled low through an open-drain enable. SCL is never driven, so the block cannot stretch the clock.

The register storage sits outside the block. Writes leave through a one-cycle strobe carrying an index and a byte. Reads take a byte from an index-addressed port that internal logic feeds. Seven registers are addressed. A parameter map marks which ones the host may write, and the rest can only be changed by the logic beside the block. A per-register bit mask forces reserved bits to zero, both on the way in and on the way out.

A write is committed only when the transaction closes with a STOP. An early STOP or a new START discards it. Read data is frozen at the moment the read address is accepted, so a concurrent update cannot tear the byte.

Top module: `smb_regslave`

## Requirements
- R1: A Write Byte to address-matched slave, command 0..3 (writable by default map), gets ACK on all three bytes and, after the STOP, exactly one single-cycle `wr_en` pulse with `wr_idx` = command and `wr_data` = data byte.
- R2: Reserved bits are zero: data is ANDed with the register's mask on write and on read; default masks are 0x07 for register 1, 0x0F for register 4, 0xFF for all others.
- R3: With `addr_sel`=0 the slave answers only address 0x2C, with `addr_sel`=1 only 0x2D; a non-matching address is NACKed and SDA is not driven again until the next START.
- R4: A Write Byte aimed at a read-only register (4, 5, 6) is acknowledged but produces no `wr_en`.
- R5: A command code of 7 or above is NACKed and no `wr_en` follows, whatever bytes come next.
- R6: A write is committed only by a STOP that follows the acknowledged data byte; a STOP or a repeated START at any earlier point, or a START in place of that STOP, produces no `wr_en`.
- R7: On a Read Byte the returned byte is the masked `rd_data` for `rd_idx` = command, sampled when the read address is accepted; later changes of `rd_data` do not affect it.
- R8: `sda_oe` changes only while SCL is low, and is asserted only in acknowledge slots and data bits sent to the host.
- R9: An address with the read bit set, not preceded in the same transaction by an accepted command, is NACKed.
- R10: Under reset `sda_oe` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| addr_sel | input | 1 | Strap picking one of the two slave addresses |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_idx | output | 3 | Register index of the write |
| wr_data | output | 8 | Masked byte to write |
| rd_idx | output | 3 | Register index currently selected for reading |
| rd_data | input | 8 | Register contents for `rd_idx` from internal logic |

## Verification
The hardest situations to reach are the ones where the bus is cut short at a protocol boundary. One is a repeated START landing right after an acknowledged data byte, where a STOP was due. Another is a STOP right after the command byte, and a third is the stored byte changing between the read address and the returned data bits. The bench's master tasks are bit-level and can be composed freely, so it places START and STOP at exactly those boundaries. The bench's register model is altered mid-read. A write scoreboard flags any strobe that the requirements do not predict.

// File: rtl/smb_regslave.sv
module smb_regslave #(
  parameter logic [6:0]  ADDR_LO  = 7'h2C,
  parameter logic [6:0]  ADDR_HI  = 7'h2D,
  parameter int          NREG     = 7,
  parameter logic [NREG-1:0] RW_MAP = 7'b0001111,
  parameter logic [8*NREG-1:0] BIT_MASK = 56'hFF_FF_0F_FF_FF_07_FF,
  localparam int         IW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          addr_sel,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic [IW-1:0] rd_idx,
  input  logic [7:0]    rd_data
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_HOLD} st_t;
  typedef enum logic [1:0] {P_ADR, P_CMD, P_DAT, P_END} ph_t;

  logic [2:0] scl_p, sda_p;
  logic       scl_s, scl_d, sda_s, sda_d;
  logic       start, stop, scl_rise, scl_fall;

  st_t        state;
  ph_t        phase;
  logic [7:0] sh, cmd, dat, txb;
  logic [2:0] cnt;
  logic       got8, have_cmd, pend, to_tx;
  logic [6:0] my_addr;

  function automatic logic [7:0] mask_of(input logic [IW-1:0] i);
    return BIT_MASK[8*i +: 8];
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  assign scl_s    = scl_p[1];
  assign scl_d    = scl_p[2];
  assign sda_s    = sda_p[1];
  assign sda_d    = sda_p[2];
  assign start    = scl_s && scl_d && sda_d && !sda_s;
  assign stop     = scl_s && scl_d && !sda_d && sda_s;
  assign scl_rise = scl_s && !scl_d;
  assign scl_fall = !scl_s && scl_d;
  assign my_addr  = addr_sel ? ADDR_HI : ADDR_LO;
  assign rd_idx   = cmd[IW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      phase    <= P_ADR;
      sh       <= '0;
      cmd      <= '0;
      dat      <= '0;
      txb      <= '0;
      cnt      <= '0;
      got8     <= 1'b0;
      have_cmd <= 1'b0;
      pend     <= 1'b0;
      to_tx    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start) begin
        have_cmd <= have_cmd && phase == P_DAT && state == S_RX;
        state    <= S_RX;
        phase    <= P_ADR;
        cnt      <= '0;
        got8     <= 1'b0;
        pend     <= 1'b0;
        to_tx    <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop) begin
        if (pend && RW_MAP[cmd[IW-1:0]]) begin
          wr_en   <= 1'b1;
          wr_idx  <= cmd[IW-1:0];
          wr_data <= dat;
        end
        state    <= S_IDLE;
        phase    <= P_ADR;
        pend     <= 1'b0;
        have_cmd <= 1'b0;
        to_tx    <= 1'b0;
        sda_oe   <= 1'b0;
      end else begin
        case (state)
          S_RX:
            if (scl_rise && !got8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) got8 <= 1'b1;
            end else if (scl_fall && got8) begin
              got8 <= 1'b0;
              cnt  <= '0;
              state <= S_HOLD;
              case (phase)
                P_ADR:
                  if (sh[7:1] == my_addr && (!sh[0] || have_cmd)) begin
                    sda_oe <= 1'b1;
                    state  <= S_ACK;
                    to_tx  <= sh[0];
                    if (sh[0]) begin
                      txb   <= rd_data & mask_of(cmd[IW-1:0]);
                      phase <= P_END;
                    end else begin
                      phase <= P_CMD;
                    end
                  end
                P_CMD:
                  if (sh < 8'(NREG)) begin
                    sda_oe   <= 1'b1;
                    state    <= S_ACK;
                    cmd      <= sh;
                    have_cmd <= 1'b1;
                    phase    <= P_DAT;
                  end
                P_DAT: begin
                  sda_oe <= 1'b1;
                  state  <= S_ACK;
                  dat    <= sh & mask_of(cmd[IW-1:0]);
                  pend   <= 1'b1;
                  phase  <= P_END;
                end
                default: ;
              endcase
            end
          S_ACK:
            if (scl_fall) begin
              if (to_tx) begin
                state  <= S_TX;
                sda_oe <= ~txb[7];
                cnt    <= '0;
              end else begin
                sda_oe <= 1'b0;
                state  <= (phase == P_END) ? S_HOLD : S_RX;
              end
            end
          S_TX:
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0;
                state  <= S_HOLD;
              end else begin
                cnt    <= cnt + 3'd1;
                txb    <= {txb[6:0], 1'b0};
                sda_oe <= ~txb[6];
              end
            end
          default: ;
        endcase
      end
    end

endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk #(
  parameter int NREG = 7,
  parameter logic [NREG-1:0] RW_MAP = 7'b0001111,
  parameter logic [8*NREG-1:0] BIT_MASK = 56'hFF_FF_0F_FF_FF_07_FF,
  localparam int IW = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_i,
  input logic          sda_oe,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [7:0]    wr_data
);

  always_comb
    if (!rst_n) assert_reset_quiet_R10: assert (!sda_oe && !wr_en);

  assert_wr_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_wr_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data & ~BIT_MASK[8*wr_idx +: 8]) == 8'h00);

  assert_wr_rw_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> RW_MAP[wr_idx]);

  assert_wr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx < IW'(NREG));

  assert_wr_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> scl_i && sda_i);

  assert_sda_change_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

endmodule

bind smb_regslave smb_regslave_chk #(
  .NREG(NREG), .RW_MAP(RW_MAP), .BIT_MASK(BIT_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/sim_smb_regslave.sv
module sim_smb_regslave;
  localparam int H = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe, wr_en;
  logic [2:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;
  logic sda_line;
  logic [7:0] regs [7];
  logic [7:0] bmask [7];
  int n_cmp = 0, n_bad = 0, n_wr = 0;
  bit done = 0, oe_seen = 0;
  logic [10:0] exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = (rd_idx < 3'd7) ? regs[rd_idx] : 8'hA5;

  smb_regslave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sda_oe) oe_seen = 1;
    if (wr_en) begin
      n_wr++;
      if (exp_q.size() == 0)
        check(0, "R4/R5/R6 unexpected write", {wr_idx, wr_data}, 0);
      else begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({wr_idx, wr_data} == e, t, {wr_idx, wr_data}, e);
      end
      regs[wr_idx] = wr_data;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1; tick(H); scl_m = 1; tick(H); sda_m = 0; tick(H); scl_m = 0; tick(H);
  endtask

  task automatic bus_stop;
    sda_m = 0; tick(H); scl_m = 1; tick(H); sda_m = 1; tick(H);
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H); scl_m = 1; tick(H); scl_m = 0;
    end
    sda_m = 1; tick(H); scl_m = 1; tick(H/2);
    acked = (sda_line == 1'b0);
    tick(H/2); scl_m = 0;
  endtask

  task automatic rx_byte(input bit nack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl_m = 1; tick(H/2); b[i] = sda_line; tick(H/2); scl_m = 0;
    end
    sda_m = nack; tick(H); scl_m = 1; tick(H); scl_m = 0; sda_m = 1;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                          output bit a1, output bit a2, output bit a3);
    bus_start;
    tx_byte({a, 1'b0}, a1);
    tx_byte(c, a2);
    tx_byte(d, a3);
    bus_stop;
    tick(10);
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] c, output logic [7:0] d,
                         output bit a1, output bit a2, output bit a3);
    bus_start;
    tx_byte({a, 1'b0}, a1);
    tx_byte(c, a2);
    bus_start;
    tx_byte({a, 1'b1}, a3);
    rx_byte(1'b1, d);
    bus_stop;
    tick(10);
  endtask

  task automatic expect_wr(input logic [2:0] i, input logic [7:0] d, input string t);
    exp_q.push_back({i, d});
    tag_q.push_back(t);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      summary;
    end
  end

  initial begin
    bit a1, a2, a3;
    logic [7:0] d;
    int w0;
    for (int i = 0; i < 7; i++) begin
      regs[i] = 8'h10 + 8'(i);
      bmask[i] = 8'hFF;
    end
    regs[4] = 8'hF3; regs[5] = 8'hC6; regs[6] = 8'h9E;
    bmask[1] = 8'h07; bmask[4] = 8'h0F;

    tick(3);
    check(sda_oe == 0, "R10 sda_oe in reset", sda_oe, 0);
    check(wr_en == 0, "R10 wr_en in reset", wr_en, 0);
    rst_n = 1; tick(5);

    // R1: plain write
    expect_wr(3'd0, 8'h5A, "R1 write reg0");
    do_write(7'h2C, 8'h00, 8'h5A, a1, a2, a3);
    check(a1 && a2 && a3, "R1 acks", {a1, a2, a3}, 3'b111);
    check(exp_q.size() == 0, "R1 write seen", exp_q.size(), 0);
    expect_wr(3'd3, 8'hC3, "R1 write reg3");
    do_write(7'h2C, 8'h03, 8'hC3, a1, a2, a3);
    check(exp_q.size() == 0, "R1 write reg3 seen", exp_q.size(), 0);

    // R2: reserved bits
    expect_wr(3'd1, 8'h07, "R2 masked write reg1");
    do_write(7'h2C, 8'h01, 8'hFF, a1, a2, a3);
    do_read(7'h2C, 8'h01, d, a1, a2, a3);
    check(a1 && a2 && a3, "R2 read acks", {a1, a2, a3}, 3'b111);
    check(d == 8'h07, "R2 read reg1", d, 8'h07);
    do_read(7'h2C, 8'h04, d, a1, a2, a3);
    check(d == (regs[4] & bmask[4]), "R2 read reg4 masked", d, regs[4] & bmask[4]);
    do_read(7'h2C, 8'h00, d, a1, a2, a3);
    check(d == 8'h5A, "R7 read reg0", d, 8'h5A);

    // R3: address strap
    w0 = n_wr;
    bus_start;
    tx_byte({7'h2D, 1'b0}, a1);
    check(!a1, "R3 wrong address nacked", a1, 0);
    oe_seen = 0;
    tx_byte(8'h00, a2);
    tx_byte(8'h00, a3);
    check(!oe_seen, "R3 silent after mismatch", oe_seen, 0);
    bus_stop; tick(10);
    check(n_wr == w0, "R3 no write", n_wr - w0, 0);
    addr_sel = 1;
    bus_start;
    tx_byte({7'h2C, 1'b0}, a1);
    bus_stop; tick(10);
    check(!a1, "R3 low address nacked when strap high", a1, 0);
    expect_wr(3'd2, 8'h81, "R3 write via strap address");
    do_write(7'h2D, 8'h02, 8'h81, a1, a2, a3);
    check(a1 && a2 && a3, "R3 strap address acks", {a1, a2, a3}, 3'b111);
    check(exp_q.size() == 0, "R3 write seen", exp_q.size(), 0);
    addr_sel = 0;

    // R4: read-only target
    w0 = n_wr;
    do_write(7'h2C, 8'h05, 8'h11, a1, a2, a3);
    check(a1 && a2 && a3, "R4 RO write acked", {a1, a2, a3}, 3'b111);
    check(n_wr == w0, "R4 no strobe", n_wr - w0, 0);
    do_read(7'h2C, 8'h05, d, a1, a2, a3);
    check(d == 8'hC6, "R4 RO content kept", d, 8'hC6);

    // R5: invalid command
    w0 = n_wr;
    do_write(7'h2C, 8'h07, 8'h22, a1, a2, a3);
    check(a1 && !a2, "R5 cmd 7 nacked", {a1, a2}, 2'b10);
    do_write(7'h2C, 8'h80, 8'h22, a1, a2, a3);
    check(!a2 && !a3, "R5 cmd 0x80 nacked", {a2, a3}, 2'b00);
    check(n_wr == w0, "R5 no strobe", n_wr - w0, 0);

    // R6: aborted writes
    w0 = n_wr;
    bus_start;
    tx_byte({7'h2C, 1'b0}, a1);
    tx_byte(8'h00, a2);
    tx_byte(8'h33, a3);
    bus_start;
    bus_stop; tick(10);
    check(a3 && n_wr == w0, "R6 START instead of STOP", n_wr - w0, 0);
    bus_start;
    tx_byte({7'h2C, 1'b0}, a1);
    tx_byte(8'h00, a2);
    bus_stop; tick(10);
    check(n_wr == w0, "R6 STOP after command", n_wr - w0, 0);
    do_read(7'h2C, 8'h00, d, a1, a2, a3);
    check(d == 8'h5A, "R6 reg0 unchanged", d, 8'h5A);

    // R7: capture at address acceptance
    bus_start;
    tx_byte({7'h2C, 1'b0}, a1);
    tx_byte(8'h06, a2);
    bus_start;
    tx_byte({7'h2C, 1'b1}, a3);
    regs[6] = 8'h01;
    rx_byte(1'b1, d);
    bus_stop; tick(10);
    check(a3 && d == 8'h9E, "R7 no tearing", d, 8'h9E);
    do_read(7'h2C, 8'h06, d, a1, a2, a3);
    check(d == 8'h01, "R7 new value next read", d, 8'h01);

    // R9: read with no command
    bus_start;
    tx_byte({7'h2C, 1'b1}, a1);
    bus_stop; tick(10);
    check(!a1, "R9 bare read nacked", a1, 0);

    // R8: idle bus, no drive
    tick(50);
    check(sda_oe == 0, "R8 released when idle", sda_oe, 0);
    check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);

    done = 1;
    summary;
  end
endmodule